// File: doc/BRIEF.md
# Clock-Control Serial Register Slave

This block is the two-wire serial slave of a clock-distribution chip. It watches the clock and data lines of the bus by sampling them with the system clock. It holds a small bank of byte-wide control registers, and from two of those registers it produces the enable vector that gates the six differential clock pairs of the chip. A disabled pair has its gate signal held low.

Every transfer uses a fixed block frame. A write carries the slave address, a command byte and a count byte, in that order. The command and count bytes are acknowledged and then thrown away. The data bytes that follow always fill the registers from index 0 upward. A read returns a count byte first and then the registers in ascending order.

The enable vector is reloaded from the registers only when a stop condition closes the frame. A frame that is interrupted or still in progress therefore never moves the clock gates.

Top module: `ccs_ctrl_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 plus the direction bit. Any other address is not acknowledged. After an address that does not match, every byte is ignored and left unacknowledged until the next start condition.
- R2: In a write, the two bytes that follow the address (command, then count) are each acknowledged. Their values have no effect on any register.
- R3: In a write, the data bytes are stored in registers 0, 1, 2 and upward in strictly ascending order, and each one is acknowledged.
- R4: A stop sent after any complete data byte keeps every register written so far. The registers not yet reached keep their previous values.
- R5: In a read, after acknowledging the address, the slave sends a count byte of value 6. It then sends registers 0 to 5 in order, with the most significant bit first.
- R6: After reset, registers 0 and 1 hold 0xFF, register 5 holds 0x06 and registers 2 to 4 hold 0x00. At the same time the enable vector is all ones and SDA is not pulled.
- R7: The enable for pair 0 is register 0 bit 7. Pair 1 is register 0 bit 6, pair 2 is register 0 bit 3, pair 3 is register 1 bit 6, pair 4 is register 0 bit 0 and pair 5 is register 0 bit 2. A value of 1 enables the pair.
- R8: In a write, a data byte beyond register 5 is not acknowledged and is discarded.
- R9: If the host answers a read byte with a NACK, or has already received register 5, the slave stops pulling SDA until the next start condition.
- R10: A repeated start, given in any state, returns the slave to address reception. The registers written before it are kept.
- R11: The enable vector changes only as a result of a stop condition. Register writes and repeated starts alone leave it unchanged.
- R12: The SDA pull-down output changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| pair_en_o | output | 6 | Gate enable per differential clock pair, bit n is pair n |

## Verification
The bench builds the block with its default parameters: address 0x69, six registers and a two-stage line synchronizer. With six registers, the overflow byte and the read-past-the-end byte fall inside short frames, so both ends of the register window are exercised directly. The two-stage synchronizer keeps the slave's reaction to each SCL edge to a few system clocks. That lets a bus quarter-bit of sixteen system clocks check the acknowledge and data timing without a long run.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;

   localparam int BYTE_W = 8;
   localparam int PAIRS  = 6;

   // source register and bit for each clock pair enable
   localparam int MAP_REG [PAIRS] = '{0, 0, 0, 1, 0, 0};
   localparam int MAP_BIT [PAIRS] = '{7, 6, 3, 6, 0, 2};

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_WAIT
   } frame_st_t;

   function automatic logic [BYTE_W-1:0] ccs_reset_val(input int idx);
      case (idx)
         0, 1:    return 8'hFF;
         5:       return 8'h06;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ccs_line_sync.sv
`timescale 1ns/1ps
module ccs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ccs_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_p;
   logic [STAGES-1:0] sda_p;
   logic              scl_d;
   logic              sda_d;

   // idle bus is high on both lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_p <= {scl_p[STAGES-2:0], scl_i};
         sda_p <= {sda_p[STAGES-2:0], sda_i};
         scl_d <= scl_p[STAGES-1];
         sda_d <= sda_p[STAGES-1];
      end
   end

   assign scl_s     = scl_p[STAGES-1];
   assign sda_s     = sda_p[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/ccs_regs.sv
`timescale 1ns/1ps
module ccs_regs
   import ccs_pkg::*;
#(
   parameter  int NUM_REGS = 6,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_data,
   output logic [PAIRS-1:0]  en_next
);

   logic [NUM_REGS*BYTE_W-1:0] regs_flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= ccs_reset_val(i);
         else if (wr_en && wr_idx == IDX_W'(i))
            q <= wr_data;
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = q;
   end

   assign rd_data = (int'(rd_idx) < NUM_REGS) ? regs_flat[rd_idx*BYTE_W +: BYTE_W] : 8'hFF;

   for (genvar p = 0; p < PAIRS; p++) begin : g_map
      assign en_next[p] = regs_flat[MAP_REG[p]*BYTE_W + MAP_BIT[p]];
   end

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_REGS)); // R8

endmodule

// File: rtl/ccs_frame.sv
`timescale 1ns/1ps
module ccs_frame
   import ccs_pkg::*;
#(
   parameter  logic [6:0] SLV_ADDR = 7'h69,
   parameter  int         NUM_REGS = 6,
   localparam int         IDX_W    = $clog2(NUM_REGS),
   localparam int         POS_W    = $clog2(NUM_REGS + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              sda_pull,
   output logic              commit
);

   localparam logic [POS_W-1:0]  HDR_END  = POS_W'(2);
   localparam logic [POS_W-1:0]  WR_END   = POS_W'(NUM_REGS + 2);
   localparam logic [POS_W-1:0]  RD_LAST  = POS_W'(NUM_REGS);
   localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(NUM_REGS);

   frame_st_t         st;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [POS_W-1:0]  pos;
   logic              is_read;
   logic              ack_ok;
   logic [BYTE_W-1:0] tx_byte;

   assign rd_idx  = IDX_W'(pos - 1'b1);
   assign tx_byte = (pos == '0) ? CNT_BYTE : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         pos      <= '0;
         is_read  <= 1'b0;
         ack_ok   <= 1'b0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         commit   <= 1'b0;
      end else begin
         wr_en  <= 1'b0;
         commit <= 1'b0;
         if (start_det) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            pos      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
            commit   <= 1'b1;
         end else begin
            case (st)
               ST_ADDR, ST_RX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (st == ST_ADDR) begin
                        if (shreg[7:1] == SLV_ADDR) begin
                           is_read  <= shreg[0];
                           sda_pull <= 1'b1;
                           st       <= ST_ACK;
                        end else begin
                           st <= ST_WAIT;
                        end
                     end else if (pos < HDR_END) begin
                        sda_pull <= 1'b1;
                        pos      <= pos + 1'b1;
                        st       <= ST_ACK;
                     end else if (pos < WR_END) begin
                        wr_en    <= 1'b1;
                        wr_idx   <= IDX_W'(pos - HDR_END);
                        wr_data  <= shreg;
                        sda_pull <= 1'b1;
                        pos      <= pos + 1'b1;
                        st       <= ST_ACK;
                     end else begin
                        sda_pull <= 1'b0;
                        st       <= ST_ACK;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (is_read) begin
                        shreg    <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                        pos      <= pos + 1'b1;
                        st       <= ST_TX;
                     end else begin
                        sda_pull <= 1'b0;
                        st       <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                        st       <= ST_TXACK;
                     end else begin
                        shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~shreg[6];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     ack_ok <= ~sda_s;
                  end else if (scl_fall) begin
                     if (ack_ok && pos <= RD_LAST) begin
                        shreg    <= tx_byte;
                        sda_pull <= ~tx_byte[7];
                        pos      <= pos + 1'b1;
                        bitcnt   <= '0;
                        st       <= ST_TX;
                     end else begin
                        st <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s); // R12

   AST_QUIET_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_WAIT) |-> !sda_pull); // R9

   AST_WRITE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !is_read); // R3

endmodule

// File: rtl/ccs_ctrl_slave.sv
`timescale 1ns/1ps
module ccs_ctrl_slave
   import ccs_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 6,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_pull_o,
   output logic [PAIRS-1:0] pair_en_o
);

   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 250) begin : g_bad_regs
      $error("ccs_ctrl_slave: NUM_REGS must lie in 2..250");
   end

   logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              wr_en, commit;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [BYTE_W-1:0] wr_data, rd_data;
   logic [PAIRS-1:0]  en_next;
   logic [PAIRS-1:0]  pair_en_q;

   ccs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   ccs_frame #(.SLV_ADDR(SLV_ADDR), .NUM_REGS(NUM_REGS)) u_frame (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
      .sda_pull(sda_pull_o), .commit(commit)
   );

   ccs_regs #(.NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .en_next(en_next)
   );

   // reset value matches the mapped reset contents of registers 0 and 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pair_en_q <= '1;
      else if (commit)
         pair_en_q <= en_next;
   end

   assign pair_en_o = pair_en_q;

   AST_EN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pair_en_q) |-> $past(commit)); // R11

endmodule

// File: tb/sim_ccs_ctrl_slave.sv
`timescale 1ns/1ps
module sim_ccs_ctrl_slave;

   localparam int Q = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_pull;
   logic [5:0] pair_en;
   logic       sda_bus;

   int checks = 0;
   int errors = 0;
   int r12_viol = 0;

   logic [7:0] rb [6];
   logic [7:0] rcnt;

   always #2.5 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull;

   ccs_ctrl_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .pair_en_o(pair_en)
   );

   // R12 monitor: pull-down must not move while the host holds SCL high
   logic prev_pull = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_pull !== prev_pull && m_scl) r12_viol++;
      prev_pull <= sda_pull;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic hq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; hq();
      m_scl = 1'b1; hq();
      m_sda = 1'b0; hq();
      m_scl = 1'b0; hq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hq();
      m_scl = 1'b1; hq();
      m_sda = 1'b1; hq();
      hq();
   endtask

   task automatic wbit(input logic b);
      m_sda = b; hq();
      m_scl = 1'b1; hq(); hq();
      m_scl = 1'b0; hq();
   endtask

   task automatic rbit(output logic v);
      m_sda = 1'b1; hq();
      m_scl = 1'b1; hq();
      v = sda_bus; hq();
      m_scl = 1'b0; hq();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic nack);
      for (int i = 7; i >= 0; i--) wbit(b[i]);
      rbit(nack);
   endtask

   task automatic rbyte(input logic send_nack, output logic [7:0] b);
      logic v;
      for (int i = 7; i >= 0; i--) begin
         rbit(v);
         b[i] = v;
      end
      wbit(send_nack);
   endtask

   task automatic read_all();
      logic nk;
      bus_start();
      wbyte(8'hD3, nk);
      chk("R1 read address ack", nk, 1'b0);
      rbyte(1'b0, rcnt);
      for (int i = 0; i < 6; i++) rbyte(i == 5, rb[i]);
      bus_stop();
   endtask

   task automatic expect_regs(input string tag, input logic [47:0] exp);
      read_all();
      chk({tag, " count"}, rcnt, 8'h06);
      for (int i = 0; i < 6; i++) chk(tag, rb[i], exp[47-8*i -: 8]);
   endtask

   // header then n data bytes; returns ack bits (1 = nack) of the data bytes
   task automatic write_frame(input logic [7:0] cmd, input logic [7:0] cnt,
                              input int n, input logic [63:0] d,
                              input logic do_stop, output logic [7:0] nks);
      logic nk;
      nks = '0;
      bus_start();
      wbyte(8'hD2, nk);  chk("R1 write address ack", nk, 1'b0);
      wbyte(cmd, nk);    chk("R2 command ack", nk, 1'b0);
      wbyte(cnt, nk);    chk("R2 count ack", nk, 1'b0);
      for (int i = 0; i < n; i++) begin
         wbyte(d[63-8*i -: 8], nk);
         nks[i] = nk;
      end
      if (do_stop) bus_stop();
   endtask

   task automatic t_reset();
      chk("R6 enables after reset", pair_en, 6'h3F);
      chk("R6 sda released after reset", sda_pull, 1'b0);
      expect_regs("R6 R5 reset contents", 48'hFFFF_0000_0006);
   endtask

   task automatic t_full_write();
      logic [7:0] nks;
      write_frame(8'h5A, 8'h01, 6, 64'h8000_1122_3344_0000, 1'b0, nks);
      chk("R3 six data bytes acked", nks, 8'h00);
      chk("R11 enables before stop", pair_en, 6'h3F);
      bus_stop();
      chk("R7 pair0 only", pair_en, 6'h01);
      expect_regs("R3 R2 full write readback", 48'h8000_1122_3344);
   endtask

   task automatic t_map();
      logic [7:0] nks;
      write_frame(8'h00, 8'h02, 2, 64'h4D40_0000_0000_0000, 1'b1, nks);
      chk("R7 pairs 1..5", pair_en, 6'h3E);
      write_frame(8'hFF, 8'hFF, 2, 64'h0800_0000_0000_0000, 1'b1, nks);
      chk("R7 pair2 only", pair_en, 6'h04);
      write_frame(8'h33, 8'h06, 2, 64'h0500_0000_0000_0000, 1'b1, nks);
      chk("R7 pairs 4 and 5", pair_en, 6'h30);
   endtask

   task automatic t_partial();
      logic [7:0] nks;
      write_frame(8'h12, 8'h06, 1, 64'hC000_0000_0000_0000, 1'b1, nks);
      chk("R4 one byte acked", nks[0], 1'b0);
      chk("R4 enables from partial write", pair_en, 6'h03);
      expect_regs("R4 partial write keeps rest", 48'hC000_1122_3344);
   endtask

   task automatic t_overflow();
      logic [7:0] nks;
      write_frame(8'h00, 8'h06, 7, 64'hA1A2_A3A4_A5A6_A700, 1'b1, nks);
      chk("R8 first six acked", nks[5:0], 6'h00);
      chk("R8 seventh byte nacked", nks[6], 1'b1);
      chk("R8 enables", pair_en, 6'h11);
      expect_regs("R8 overflow discarded", 48'hA1A2_A3A4_A5A6);
   endtask

   task automatic t_badaddr();
      logic nk;
      bus_start();
      wbyte(8'hA0, nk); chk("R1 foreign address nacked", nk, 1'b1);
      wbyte(8'hD2, nk); chk("R1 later byte ignored", nk, 1'b1);
      wbyte(8'h00, nk); chk("R1 later byte ignored 2", nk, 1'b1);
      bus_stop();
      chk("R1 enables unchanged", pair_en, 6'h11);
      expect_regs("R1 registers unchanged", 48'hA1A2_A3A4_A5A6);
   endtask

   task automatic t_release();
      logic nk;
      logic [7:0] b;
      bus_start();
      wbyte(8'hD3, nk);
      chk("R9 address ack", nk, 1'b0);
      rbyte(1'b1, b);
      chk("R5 count byte", b, 8'h06);
      rbyte(1'b1, b);
      chk("R9 released after host nack", b, 8'hFF);
      bus_stop();
      read_all();
      rbyte(1'b1, b);
      bus_start();
      bus_stop();
      bus_start();
      wbyte(8'hD3, nk);
      for (int i = 0; i < 7; i++) rbyte(1'b0, b);
      chk("R5 register 5 last", b, 8'hA6);
      rbyte(1'b1, b);
      chk("R9 released past last register", b, 8'hFF);
      bus_stop();
   endtask

   task automatic t_rstart();
      logic [7:0] nks;
      logic nk;
      logic [7:0] b;
      write_frame(8'h00, 8'h06, 1, 64'h0000_0000_0000_0000, 1'b0, nks);
      chk("R10 data acked", nks[0], 1'b0);
      bus_start();
      chk("R11 enables after repeated start", pair_en, 6'h11);
      wbyte(8'hD3, nk);
      chk("R10 address after repeated start", nk, 1'b0);
      rbyte(1'b0, b);
      chk("R10 count after repeated start", b, 8'h06);
      rbyte(1'b1, b);
      chk("R10 register 0 kept", b, 8'h00);
      bus_stop();
      chk("R11 enables at stop", pair_en, 6'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t_reset();
      t_full_write();
      t_map();
      t_partial();
      t_overflow();
      t_badaddr();
      t_release();
      t_rstart();
      chk("R12 pull changes only with SCL low", r12_viol, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule